// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns a single machine-cycle request into the clocked strobe sequence of a small 8-bit processor bus. On that bus the low address byte and the data share one set of wires, and the high address byte has dedicated wires of its own. A request carries a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through T-states of one clock each. In the first T-state it pulses an active-high latch strobe while the low address byte sits on the shared bus, so that an external latch can hold it. In the next two T-states it drives an active-low read or write strobe. Three status bits name the cycle kind for the whole length of the cycle.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the sequencer is empty or in the last T-state of its current cycle. A request held with `req_valid` high while `req_ready` is low waits, unchanged, until the next acceptance point. An accepted request starts T1 on the following clock, so cycles can run back to back with no gap. Read data is captured from the shared bus at the end of T3 and presented for one clock with a qualifying pulse. That pulse has no back-pressure.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0, `done` and `rdata_valid` are 0, the status bits are 000 and `req_ready` is 1.
- R2: The cycle kinds are encoded on `req_kind` as 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. Each drives {`io_m`,`s1`,`s0`} = 011, 010, 001, 110 and 101 respectively. This value is set from T1 and held unchanged through the last T-state of the cycle. While no cycle runs the status is 000.
- R3: `ale` is 1 only in T1 of a non-idle cycle and is 0 in every other T-state.
- R4: In T1 of a non-idle cycle `ad_oe` is 1 and `ad_out` equals address bits [7:0]. `addr_hi` carries address bits [15:8] throughout a non-idle cycle and is 0 otherwise.
- R5: `rd_n` is 0 exactly in T2 and T3 of opcode fetch, memory read and I/O read cycles. `wr_n` is 0 exactly in T2 and T3 of memory write and I/O write cycles. The two are never 0 together.
- R6: In a write cycle `ad_oe` is 1 and `ad_out` equals the request's data byte from the start of T2 through T3.
- R7: In a read-type cycle `ad_oe` is 0 from T2 to the end of the cycle. The value on `ad_in` during T3 is captured at the clock edge that ends T3 and appears on `rdata` with `rdata_valid` high for exactly the next clock.
- R8: An opcode fetch lasts 4 T-states, and its T4 has both strobes inactive. Every other kind lasts 3 T-states. `done` is high exactly in the last T-state.
- R9: `req_ready` is 1 only when no cycle runs or in the last T-state. A request accepted in the last T-state starts T1 on the very next clock.
- R10: A bus idle cycle (`req_kind` 5, with 6 and 7 treated the same) lasts 3 T-states. Throughout it `ale` is 0, both strobes are 1, `ad_oe` is 0 and the status is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_kind | input | 3 | Machine cycle kind |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data byte |
| ad_out | output | 8 | Shared address/data bus, driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, sampled value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | One-clock qualifier for `rdata` |
| done | output | 1 | Last T-state of the running cycle |

## Verification
The end of a 3-state read is the edge where most things meet. At that single edge T3 data is captured from `ad_in`, the cycle is marked done, and the next request is accepted. The next cycle's T1 then drives a fresh address onto the same shared bus while `rdata` still presents the old byte. This is provoked with back-to-back read-then-write and read-then-read streams, in which `ad_in` changes every clock. The bench's reference model judges each clock that the captured byte is the one present during T3, not during T1 of the successor. It also judges that the new cycle's status and latch strobe start with no gap.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_IDLE  = 3'd5
  } cyc_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  function automatic cyc_kind_e sanitize_kind(input logic [2:0] raw);
    cyc_kind_e k;
    case (raw)
      3'd0: k = CYC_FETCH;
      3'd1: k = CYC_MRD;
      3'd2: k = CYC_MWR;
      3'd3: k = CYC_IORD;
      3'd4: k = CYC_IOWR;
      default: k = CYC_IDLE;
    endcase
    return k;
  endfunction

  function automatic logic kind_reads(input cyc_kind_e k);
    return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  function automatic logic kind_writes(input cyc_kind_e k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic status_t kind_status(input cyc_kind_e k);
    status_t s;
    case (k)
      CYC_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      CYC_MRD:   s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      CYC_MWR:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      CYC_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      CYC_IOWR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
  import bus_seq_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3,
  parameter int IDLE_T  = 3,
  parameter int TW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic          active,
  output logic [TW-1:0] tcnt,
  output cyc_kind_e     kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);

  logic [TW-1:0] len_cur;
  logic          last_t;
  logic          accept;

  always_comb begin
    case (kind)
      CYC_FETCH: len_cur = TW'(FETCH_T);
      CYC_IDLE:  len_cur = TW'(IDLE_T);
      default:   len_cur = TW'(XFER_T);
    endcase
  end

  assign last_t    = active && (tcnt == len_cur);
  assign req_ready = !active || last_t;
  assign done      = last_t;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tcnt   <= '0;
      kind   <= CYC_IDLE;
      addr   <= '0;
      wdata  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      tcnt   <= TW'(1);
      kind   <= sanitize_kind(req_kind);
      addr   <= req_addr;
      wdata  <= req_wdata;
    end else if (last_t) begin
      active <= 1'b0;
      tcnt   <= '0;
    end else if (active) begin
      tcnt   <= tcnt + TW'(1);
    end
  end

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import bus_seq_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          active,
  input  logic [TW-1:0] tcnt,
  input  cyc_kind_e     kind,
  output logic          ale,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic          rd_n,
  output logic          wr_n,
  output logic          xfer_win
);

  logic    bus_cycle;
  status_t st;

  assign bus_cycle = active && (kind != CYC_IDLE);
  assign xfer_win  = active && ((tcnt == TW'(2)) || (tcnt == TW'(3)));

  always_comb begin
    if (active) st = kind_status(kind);
    else        st = '0;
  end

  assign io_m = st.io_m;
  assign s1   = st.s1;
  assign s0   = st.s0;
  assign ale  = bus_cycle && (tcnt == TW'(1));
  assign rd_n = !(xfer_win && kind_reads(kind));
  assign wr_n = !(xfer_win && kind_writes(kind));

endmodule

// File: rtl/bus_path.sv
module bus_path
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [TW-1:0] tcnt,
  input  cyc_kind_e     kind,
  input  logic          xfer_win,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid
);

  logic bus_cycle;
  logic in_t1;
  logic wr_drive;
  logic capture;

  assign bus_cycle = active && (kind != CYC_IDLE);
  assign in_t1     = bus_cycle && (tcnt == TW'(1));
  assign wr_drive  = xfer_win && kind_writes(kind);
  assign capture   = active && kind_reads(kind) && (tcnt == TW'(3));

  always_comb begin
    ad_oe  = in_t1 || wr_drive;
    ad_out = '0;
    if (in_t1)         ad_out = addr[DW-1:0];
    else if (wr_drive) ad_out = wdata;
  end

  assign addr_hi = bus_cycle ? addr[AW-1:DW] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= capture;
      if (capture) rdata <= ad_in;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3,
  parameter int IDLE_T  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] addr_hi,
  output logic             ale,
  output logic             io_m,
  output logic             s1,
  output logic             s0,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_valid,
  output logic             done
);

  localparam int MAX_A = (FETCH_T > XFER_T) ? FETCH_T : XFER_T;
  localparam int MAX_T = (MAX_A > IDLE_T) ? MAX_A : IDLE_T;
  localparam int TW    = $clog2(MAX_T + 1);

  logic          active;
  logic [TW-1:0] tcnt;
  cyc_kind_e     kind;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          xfer_win;

  cycle_ctrl #(
    .AW(AW), .DW(DW), .FETCH_T(FETCH_T), .XFER_T(XFER_T),
    .IDLE_T(IDLE_T), .TW(TW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .done      (done),
    .active    (active),
    .tcnt      (tcnt),
    .kind      (kind),
    .addr      (addr),
    .wdata     (wdata)
  );

  strobe_gen #(.TW(TW)) u_strobe (
    .active   (active),
    .tcnt     (tcnt),
    .kind     (kind),
    .ale      (ale),
    .io_m     (io_m),
    .s1       (s1),
    .s0       (s0),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .xfer_win (xfer_win)
  );

  bus_path #(.AW(AW), .DW(DW), .TW(TW)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .tcnt        (tcnt),
    .kind        (kind),
    .xfer_win    (xfer_win),
    .addr        (addr),
    .wdata       (wdata),
    .ad_in       (ad_in),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .addr_hi     (addr_hi),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic ale,
  input logic io_m,
  input logic s1,
  input logic s0,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable({io_m, s1, s0}));

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R10
  ale_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ({io_m, s1, s0} != 3'b000));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .ale       (ale),
  .io_m      (io_m),
  .s1        (s1),
  .s0        (s0),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in = '0;
  logic [7:0]  addr_hi;
  logic        ale, io_m, s1, s0, rd_n, wr_n;
  logic [7:0]  rdata;
  logic        rdata_valid;
  logic        done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
    .rdata(rdata), .rdata_valid(rdata_valid), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // request stream: kind, addr, wdata, gap (idle clocks before offering)
  int q_kind[$];
  int q_addr[$];
  int q_wd[$];
  int q_gap[$];

  // reference model state
  int m_kind = 5;
  int m_t = 0;
  int m_len = 3;
  int m_addr = 0;
  int m_wd = 0;
  int m_rd = 0;
  bit m_rv = 0;
  int gap = 0;
  int fetch_len_seen = 0;

  function automatic int status_of(int k);
    case (k)
      0: return 3;
      1: return 2;
      2: return 1;
      3: return 6;
      4: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_rd(int k);
    return k == 0 || k == 1 || k == 3;
  endfunction

  function automatic bit is_wr(int k);
    return k == 2 || k == 4;
  endfunction

  task automatic add_req(int k, int a, int w, int g);
    q_kind.push_back(k); q_addr.push_back(a); q_wd.push_back(w); q_gap.push_back(g);
  endtask

  task automatic compare_all();
    bit act = (m_t != 0);
    bit idle = (m_kind == 5);
    bit nonidle = act && !idle;
    bit xw = act && (m_t == 2 || m_t == 3);
    int e_oe = (nonidle && (m_t == 1 || (is_wr(m_kind) && xw))) ? 1 : 0;
    int e_st = act ? status_of(m_kind) : 0;
    string stag = (act && idle) ? "R10" : "R2";
    check(stag, "status", {io_m, s1, s0}, e_st);
    check((act && idle) ? "R10" : "R3", "ale", ale, (nonidle && m_t == 1) ? 1 : 0);
    check("R5", "rd_n", rd_n, (xw && is_rd(m_kind)) ? 0 : 1);
    check("R5", "wr_n", wr_n, (xw && is_wr(m_kind)) ? 0 : 1);
    if (act && is_rd(m_kind) && m_t >= 2) check("R7", "ad_oe read", ad_oe, 0);
    else if (act && is_wr(m_kind) && m_t >= 2) check("R6", "ad_oe write", ad_oe, e_oe);
    else check((act && idle) ? "R10" : "R4", "ad_oe", ad_oe, e_oe);
    if (nonidle && m_t == 1) check("R4", "ad_out addr", ad_out, m_addr & 8'hff);
    if (act && is_wr(m_kind) && xw) check("R6", "ad_out data", ad_out, m_wd);
    check("R4", "addr_hi", addr_hi, nonidle ? (m_addr >> 8) : 0);
    check("R8", "done", done, (act && m_t == m_len) ? 1 : 0);
    check("R9", "req_ready", req_ready, (!act || m_t == m_len) ? 1 : 0);
    check("R7", "rdata_valid", rdata_valid, m_rv);
    if (m_rv) check("R7", "rdata", rdata, m_rd);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int cyc = 0;
    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    check("R1", "rd_n", rd_n, 1);
    check("R1", "wr_n", wr_n, 1);
    check("R1", "ale", ale, 0);
    check("R1", "ad_oe", ad_oe, 0);
    check("R1", "done", done, 0);
    check("R1", "rdata_valid", rdata_valid, 0);
    check("R1", "status", {io_m, s1, s0}, 0);
    check("R1", "req_ready", req_ready, 1);
    rst_n = 1'b1;

    add_req(0, 16'h1234, 8'h00, 1);
    add_req(1, 16'hA05C, 8'h00, 2);
    add_req(2, 16'h40F1, 8'h5A, 0);
    add_req(3, 16'h0077, 8'h00, 3);
    add_req(4, 16'h00C3, 8'hE7, 0);
    add_req(5, 16'hFFFF, 8'h11, 1);
    add_req(7, 16'h8001, 8'h22, 0);
    // back-to-back reads and read-then-write (capture meets acceptance)
    add_req(1, 16'h2211, 8'h00, 0);
    add_req(1, 16'h3322, 8'h00, 0);
    add_req(2, 16'h4433, 8'h99, 0);
    add_req(3, 16'h5544, 8'h00, 0);
    add_req(4, 16'h6655, 8'h3C, 0);
    add_req(0, 16'h7766, 8'h00, 0);
    add_req(0, 16'h8877, 8'h00, 0);
    add_req(5, 16'h0102, 8'h00, 0);
    add_req(1, 16'h9988, 8'h00, 0);
    add_req(6, 16'h1111, 8'h00, 0);
    add_req(2, 16'hFEDC, 8'hA5, 2);
    add_req(0, 16'hBEEF, 8'h00, 0);
    gap = q_gap[0];

    for (int n = 0; n < 140; n++) begin
      bit act, accept, cap;
      @(negedge clk);
      compare_all();
      // choose inputs
      cyc++;
      ad_in = 8'((cyc * 37 + 5) & 8'hff);
      if (q_kind.size() != 0 && gap == 0) begin
        req_valid = 1'b1;
        req_kind = 3'(q_kind[0]);
        req_addr = 16'(q_addr[0]);
        req_wdata = 8'(q_wd[0]);
      end else begin
        req_valid = 1'b0;
        req_kind = 3'(n % 8);
        req_addr = 16'(n * 311);
        req_wdata = 8'(n);
        if (gap > 0) gap--;
      end
      // model next state
      act = (m_t != 0);
      accept = req_valid && (!act || m_t == m_len);
      cap = act && is_rd(m_kind) && m_t == 3;
      if (cap) m_rd = ad_in;
      m_rv = cap;
      if (act && m_t == m_len && m_kind == 0) fetch_len_seen = m_t;
      if (accept) begin
        m_kind = (q_kind[0] > 5) ? 5 : q_kind[0];
        m_addr = q_addr[0];
        m_wd = q_wd[0];
        m_len = (m_kind == 0) ? 4 : 3;
        m_t = 1;
        void'(q_kind.pop_front()); void'(q_addr.pop_front());
        void'(q_wd.pop_front()); void'(q_gap.pop_front());
        if (q_gap.size() != 0) gap = q_gap[0];
      end else if (act && m_t == m_len) begin
        m_t = 0;
      end else if (act) begin
        m_t++;
      end
    end
    check("R9", "all requests accepted", q_kind.size(), 0);
    check("R8", "fetch length", fetch_len_seen, 4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule